// File: doc/BRIEF.md
# Delayed Write Transaction Queue

This block sits between the two sides of a bus bridge and handles single-Dword delayed writes, which are I/O writes and Type 1 configuration writes. When such a write first appears on the initiator side, the block claims it and answers with a target retry. While it does so, it records the command, address, address parity, data Dword, byte enables and data parity into a small in-order queue. A write is not recorded again while an entry with the same address and command is still held, and nothing is recorded while the queue is full. In both of those cases the initiator still gets a retry, so it comes back later.

On the target side, the oldest entry is presented as a request once an external ordering permit reports that all constraints against posted data are met. A target retry sends the same entry back to wait for the permit, and it is presented again. A completion or an error removes the entry and produces a one-cycle status pulse. Queue depth and field widths are parameters.

Top module: `dly_wr_queue`

## Requirements
- R1: While reset is held and directly after it, `ini_claim`, `ini_retry`, `tgt_req`, `stat_vld` and `q_full` are 0 and `q_count` is 0.
- R2: Only the command codes 4'b0011 (I/O write) and 4'b1011 (configuration write) are claimed. A strobe with any other code raises neither `ini_claim` nor `ini_retry` and leaves `q_count` unchanged.
- R3: After an accepted address strobe, `ini_claim` is high from the next cycle until the retry cycle ends. `ini_retry` is a one-cycle pulse in the cycle after the first cycle in which `ini_irdy` is sampled high. `ini_apar` is taken from the cycle after the strobe. Data, byte enables and `ini_dpar` are taken from the cycle in which `ini_irdy` is high.
- R4: A claimed write whose address and command pair is new, arriving while the queue is not full, adds one entry (`q_count` rises by one in the retry cycle). All six captured fields are later presented unchanged on the `tgt_*` outputs.
- R5: A claimed write whose address and command both equal those of a held entry still receives the retry but adds no entry. The same address with a different command is a new entry.
- R6: A claimed write that arrives while `q_count` equals DEPTH receives a retry and adds no entry. `q_full` is high exactly when `q_count` equals DEPTH.
- R7: `tgt_req` rises only in the cycle after a cycle in which the queue was non-empty, no request was outstanding and `tgt_permit` was high. With `tgt_permit` low, no request starts.
- R8: Entries are presented on the target side in the order in which they were accepted.
- R9: A response with code 2'b01 (retry) drops `tgt_req` in the next cycle, keeps the entry, and presents the same entry again at the next permit. No status pulse follows.
- R10: A response with code 2'b00 (done) or 2'b10/2'b11 (error) removes the head entry. In the next cycle, `stat_vld` pulses for one cycle with `stat_err` equal to 0 for done and 1 for error.
- R11: `tgt_rsp_vld` while `tgt_req` is low has no effect on `q_count`, `stat_vld` or `tgt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ini_avld | input | 1 | Address-phase strobe of a new initiator access |
| ini_cmd | input | CW | Bus command code |
| ini_addr | input | AW | Access address |
| ini_apar | input | 1 | Address parity, valid one cycle after the strobe |
| ini_irdy | input | 1 | Initiator ready, marks the data cycle |
| ini_data | input | DW | Write data Dword |
| ini_be | input | BEW | Byte enables |
| ini_dpar | input | 1 | Data parity |
| ini_claim | output | 1 | Access claimed (device select) |
| ini_retry | output | 1 | Target retry to the initiator |
| tgt_permit | input | 1 | Ordering permit for the head entry |
| tgt_req | output | 1 | Head entry presented on the target side |
| tgt_cmd | output | CW | Command of the head entry |
| tgt_addr | output | AW | Address of the head entry |
| tgt_apar | output | 1 | Address parity of the head entry |
| tgt_data | output | DW | Data of the head entry |
| tgt_be | output | BEW | Byte enables of the head entry |
| tgt_dpar | output | 1 | Data parity of the head entry |
| tgt_rsp_vld | input | 1 | Target-side response valid |
| tgt_rsp | input | 2 | Response code: 00 done, 01 retry, 10/11 error |
| stat_vld | output | 1 | One-cycle status pulse after removal |
| stat_err | output | 1 | Status: 0 done, 1 error |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_count | output | CNTW | Number of held entries |

## Verification
The embedded properties assume that the initiator keeps its data strobe within an access the block has claimed, and that the target side sends a response only while a request is outstanding. They also assume that reset is held for several cycles with all inputs low, so every past value they read is defined. The stimulus drives every access as a complete strobe, parity and data sequence through a task, and never overlaps two accesses. Permits and responses come from a second task that issues a response only after it has seen `tgt_req`. The one deliberate exception is the stray response, which is sent while no request is outstanding and is checked only at the ports.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
   localparam logic [3:0] CMD_IO_WR  = 4'b0011;
   localparam logic [3:0] CMD_CFG_WR = 4'b1011;

   localparam logic [1:0] RSP_DONE  = 2'b00;
   localparam logic [1:0] RSP_RETRY = 2'b01;

   typedef enum logic [1:0] {
      CAP_IDLE,
      CAP_APAR,
      CAP_DWAIT,
      CAP_RESP
   } cap_state_e;

   typedef enum logic {
      ISS_IDLE,
      ISS_BUSY
   } iss_state_e;
endpackage

// File: rtl/dwq_capture.sv
module dwq_capture
   import dwq_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ini_avld,
   input  logic [CW-1:0] ini_cmd,
   input  logic [AW-1:0] ini_addr,
   input  logic          ini_apar,
   input  logic          ini_irdy,
   input  logic          dup_hit,
   input  logic          full,
   output logic          ini_claim,
   output logic          ini_retry,
   output logic          push,
   output logic [CW-1:0] cap_cmd,
   output logic [AW-1:0] cap_addr,
   output logic          cap_apar
);
   cap_state_e st;
   logic       cmd_ok;

   assign cmd_ok = (ini_cmd == CW'(CMD_IO_WR)) || (ini_cmd == CW'(CMD_CFG_WR));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= CAP_IDLE;
         cap_cmd  <= '0;
         cap_addr <= '0;
         cap_apar <= 1'b0;
      end else begin
         case (st)
            CAP_IDLE: if (ini_avld && cmd_ok) begin
               cap_cmd  <= ini_cmd;
               cap_addr <= ini_addr;
               st       <= CAP_APAR;
            end
            CAP_APAR: begin
               cap_apar <= ini_apar;
               st       <= CAP_DWAIT;
            end
            CAP_DWAIT: if (ini_irdy) st <= CAP_RESP;
            default:   st <= CAP_IDLE;
         endcase
      end
   end

   assign ini_claim = (st != CAP_IDLE);
   assign ini_retry = (st == CAP_RESP);
   assign push      = (st == CAP_DWAIT) && ini_irdy && !dup_hit && !full;

   p_retry_after_irdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ini_retry |-> $past(ini_irdy));
   p_claim_follows_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ini_claim) |-> $past(ini_avld));
endmodule

// File: rtl/dwq_store.sv
module dwq_store #(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CW    = 4,
   localparam int BEW  = DW / 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [CW-1:0]   w_cmd,
   input  logic [AW-1:0]   w_addr,
   input  logic            w_apar,
   input  logic [DW-1:0]   w_data,
   input  logic [BEW-1:0]  w_be,
   input  logic            w_dpar,
   input  logic            pop,
   input  logic [CW-1:0]   look_cmd,
   input  logic [AW-1:0]   look_addr,
   output logic            dup_hit,
   output logic            full,
   output logic            nonempty,
   output logic [CNTW-1:0] count,
   output logic [CW-1:0]   h_cmd,
   output logic [AW-1:0]   h_addr,
   output logic            h_apar,
   output logic [DW-1:0]   h_data,
   output logic [BEW-1:0]  h_be,
   output logic            h_dpar
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("dwq_store: DEPTH must be a power of two of at least 2");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("dwq_store: DW must be a whole number of bytes");
   end

   logic [CW-1:0]  cmd_q  [DEPTH];
   logic [AW-1:0]  addr_q [DEPTH];
   logic [DW-1:0]  data_q [DEPTH];
   logic [BEW-1:0] be_q   [DEPTH];
   logic [DEPTH-1:0] apar_q, dpar_q, vld_q, hit;
   logic [PW-1:0]  wr_ptr, rd_ptr;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
         end else if (push && wr_ptr == PW'(i)) begin
            vld_q[i] <= 1'b1;
         end else if (pop && rd_ptr == PW'(i)) begin
            vld_q[i] <= 1'b0;
         end
      end
      always_ff @(posedge clk) begin
         if (push && wr_ptr == PW'(i)) begin
            cmd_q[i]  <= w_cmd;
            addr_q[i] <= w_addr;
            data_q[i] <= w_data;
            be_q[i]   <= w_be;
            apar_q[i] <= w_apar;
            dpar_q[i] <= w_dpar;
         end
      end
      assign hit[i] = vld_q[i] && (addr_q[i] == look_addr) && (cmd_q[i] == look_cmd);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNTW'(push) - CNTW'(pop);
      end
   end

   assign dup_hit  = |hit;
   assign full     = (count == CNTW'(DEPTH));
   assign nonempty = (count != '0);
   assign h_cmd    = cmd_q[rd_ptr];
   assign h_addr   = addr_q[rd_ptr];
   assign h_data   = data_q[rd_ptr];
   assign h_be     = be_q[rd_ptr];
   assign h_apar   = apar_q[rd_ptr];
   assign h_dpar   = dpar_q[rd_ptr];

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNTW'(DEPTH)));
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));
   p_push_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !dup_hit);
   p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/dwq_issue.sv
module dwq_issue
   import dwq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       nonempty,
   input  logic       tgt_permit,
   input  logic       tgt_rsp_vld,
   input  logic [1:0] tgt_rsp,
   output logic       tgt_req,
   output logic       pop,
   output logic       stat_vld,
   output logic       stat_err
);
   iss_state_e st;
   logic       finish;

   assign finish  = (st == ISS_BUSY) && tgt_rsp_vld;
   assign pop     = finish && (tgt_rsp != RSP_RETRY);
   assign tgt_req = (st == ISS_BUSY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ISS_IDLE;
         stat_vld <= 1'b0;
         stat_err <= 1'b0;
      end else begin
         stat_vld <= pop;
         if (pop) stat_err <= (tgt_rsp != RSP_DONE);
         case (st)
            ISS_IDLE: if (nonempty && tgt_permit) st <= ISS_BUSY;
            default:  if (finish) st <= ISS_IDLE;
         endcase
      end
   end

   p_req_needs_permit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_req) |-> ($past(tgt_permit) && $past(nonempty)));
   p_stat_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stat_vld |-> $past(tgt_rsp_vld && tgt_req));
   p_retry_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_req && tgt_rsp_vld && tgt_rsp == RSP_RETRY) |=> (!tgt_req && !stat_vld));
endmodule

// File: rtl/dly_wr_queue.sv
module dly_wr_queue #(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int CW    = 4,
   localparam int BEW  = DW / 8,
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ini_avld,
   input  logic [CW-1:0]   ini_cmd,
   input  logic [AW-1:0]   ini_addr,
   input  logic            ini_apar,
   input  logic            ini_irdy,
   input  logic [DW-1:0]   ini_data,
   input  logic [BEW-1:0]  ini_be,
   input  logic            ini_dpar,
   output logic            ini_claim,
   output logic            ini_retry,
   input  logic            tgt_permit,
   output logic            tgt_req,
   output logic [CW-1:0]   tgt_cmd,
   output logic [AW-1:0]   tgt_addr,
   output logic            tgt_apar,
   output logic [DW-1:0]   tgt_data,
   output logic [BEW-1:0]  tgt_be,
   output logic            tgt_dpar,
   input  logic            tgt_rsp_vld,
   input  logic [1:0]      tgt_rsp,
   output logic            stat_vld,
   output logic            stat_err,
   output logic            q_full,
   output logic [CNTW-1:0] q_count
);
   logic          push, pop, dup_hit, nonempty;
   logic [CW-1:0] cap_cmd;
   logic [AW-1:0] cap_addr;
   logic          cap_apar;

   dwq_capture #(.AW(AW), .CW(CW)) u_cap (
      .clk, .rst_n, .ini_avld, .ini_cmd, .ini_addr, .ini_apar, .ini_irdy,
      .dup_hit, .full(q_full), .ini_claim, .ini_retry, .push,
      .cap_cmd, .cap_addr, .cap_apar
   );

   dwq_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .CW(CW)) u_store (
      .clk, .rst_n, .push,
      .w_cmd(cap_cmd), .w_addr(cap_addr), .w_apar(cap_apar),
      .w_data(ini_data), .w_be(ini_be), .w_dpar(ini_dpar),
      .pop, .look_cmd(cap_cmd), .look_addr(cap_addr),
      .dup_hit, .full(q_full), .nonempty, .count(q_count),
      .h_cmd(tgt_cmd), .h_addr(tgt_addr), .h_apar(tgt_apar),
      .h_data(tgt_data), .h_be(tgt_be), .h_dpar(tgt_dpar)
   );

   dwq_issue u_iss (
      .clk, .rst_n, .nonempty, .tgt_permit, .tgt_rsp_vld, .tgt_rsp,
      .tgt_req, .pop, .stat_vld, .stat_err
   );

   p_head_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_req && $past(tgt_req)) |-> ($stable(tgt_addr) && $stable(tgt_cmd) && $stable(tgt_data)));
   p_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_rsp_vld && !tgt_req && !ini_retry) |=> $stable(q_count));
endmodule

// File: tb/dly_wr_queue_tb_top.sv
module dly_wr_queue_tb_top;
   localparam int DEPTH = 4;

   typedef struct packed {
      logic [3:0]  cmd;
      logic [31:0] addr;
      logic        apar;
      logic [31:0] data;
      logic [3:0]  be;
      logic        dpar;
   } ent_t;

   logic clk = 0, rst_n = 0;
   logic ini_avld = 0, ini_apar = 0, ini_irdy = 0, ini_dpar = 0;
   logic [3:0] ini_cmd = 0, ini_be = 0;
   logic [31:0] ini_addr = 0, ini_data = 0;
   logic tgt_permit = 0, tgt_rsp_vld = 0;
   logic [1:0] tgt_rsp = 0;
   logic ini_claim, ini_retry, tgt_req, tgt_apar, tgt_dpar, stat_vld, stat_err, q_full;
   logic [3:0] tgt_cmd, tgt_be;
   logic [31:0] tgt_addr, tgt_data;
   logic [2:0] q_count;

   int n_chk = 0, n_fail = 0;
   ent_t mq[$];

   always #10 clk = ~clk;

   dly_wr_queue dut_i (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit model_dup(input logic [3:0] c, input logic [31:0] a);
      foreach (mq[i]) if (mq[i].cmd == c && mq[i].addr == a) return 1'b1;
      return 1'b0;
   endfunction

   task automatic do_write(input ent_t e, input int wait_cyc);
      bit exp_add;
      int exp_cnt;
      @(negedge clk);
      ini_avld = 1; ini_cmd = e.cmd; ini_addr = e.addr;
      @(negedge clk);
      ini_avld = 0; ini_apar = e.apar;
      chk(ini_claim == 1, "R3", "claim after strobe", 64'(ini_claim), 1);
      for (int k = 0; k < wait_cyc; k++) begin
         @(negedge clk);
         ini_apar = 0;
         chk(ini_claim == 1 && ini_retry == 0, "R3", "claim while waiting", 64'({ini_claim, ini_retry}), 2);
      end
      @(negedge clk);
      ini_apar = 0; ini_irdy = 1; ini_data = e.data; ini_be = e.be; ini_dpar = e.dpar;
      exp_add = !model_dup(e.cmd, e.addr) && mq.size() < DEPTH;
      exp_cnt = mq.size() + (exp_add ? 1 : 0);
      if (exp_add) mq.push_back(e);
      @(negedge clk);
      ini_irdy = 0; ini_data = 0; ini_be = 0; ini_dpar = 0;
      chk(ini_retry == 1 && ini_claim == 1, "R3", "retry pulse", 64'({ini_claim, ini_retry}), 3);
      chk(q_count == 3'(exp_cnt), exp_add ? "R4" : "R5/R6", "count after write", 64'(q_count), 64'(exp_cnt));
      chk(q_full == (exp_cnt == DEPTH), "R6", "full flag", 64'(q_full), 64'(exp_cnt == DEPTH));
      @(negedge clk);
      chk(ini_retry == 0 && ini_claim == 0, "R3", "claim released", 64'({ini_claim, ini_retry}), 0);
   endtask

   task automatic serve(input logic [1:0] rsp);
      ent_t h;
      h = mq[0];
      chk(tgt_req == 0, "R7", "no request before permit", 64'(tgt_req), 0);
      tgt_permit = 1;
      @(negedge clk);
      tgt_permit = 0;
      chk(tgt_req == 1, "R7", "request after permit", 64'(tgt_req), 1);
      chk({tgt_cmd, tgt_addr, tgt_apar, tgt_data, tgt_be, tgt_dpar} == h, "R8", "head fields",
          64'({tgt_cmd, tgt_addr}), 64'({h.cmd, h.addr}));
      chk(tgt_data == h.data && tgt_be == h.be && tgt_apar == h.apar && tgt_dpar == h.dpar,
          "R4", "replayed data fields", 64'({tgt_data, tgt_be, tgt_apar, tgt_dpar}),
          64'({h.data, h.be, h.apar, h.dpar}));
      tgt_rsp_vld = 1; tgt_rsp = rsp;
      if (rsp != 2'b01) void'(mq.pop_front());
      @(negedge clk);
      tgt_rsp_vld = 0; tgt_rsp = 0;
      chk(tgt_req == 0, "R9", "request dropped", 64'(tgt_req), 0);
      chk(q_count == 3'(mq.size()), "R10", "count after response", 64'(q_count), 64'(mq.size()));
      if (rsp == 2'b01) begin
         chk(stat_vld == 0, "R9", "no status on retry", 64'(stat_vld), 0);
      end else begin
         chk(stat_vld == 1 && stat_err == (rsp != 2'b00), "R10", "status pulse",
             64'({stat_vld, stat_err}), 64'({1'b1, rsp != 2'b00}));
      end
      @(negedge clk);
      chk(stat_vld == 0, "R10", "status one cycle", 64'(stat_vld), 0);
   endtask

   function automatic ent_t mk(input logic [3:0] c, input logic [31:0] a);
      ent_t e;
      e.cmd = c; e.addr = a;
      e.apar = 1'($urandom); e.data = $urandom; e.be = 4'($urandom); e.dpar = 1'($urandom);
      return e;
   endfunction

   initial begin
      #(200000 * 20);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (4) @(negedge clk);
      chk(ini_claim == 0 && ini_retry == 0 && tgt_req == 0 && stat_vld == 0, "R1",
          "outputs in reset", 64'({ini_claim, ini_retry, tgt_req, stat_vld}), 0);
      rst_n = 1;
      @(negedge clk);
      chk(q_count == 0 && q_full == 0, "R1", "queue empty after reset", 64'({q_full, q_count}), 0);

      do_write(mk(4'b0011, 32'h100), 2);
      do_write(mk(4'b0011, 32'h100), 0);     // R5 duplicate
      do_write(mk(4'b1011, 32'h100), 1);     // R5 same address, other command

      // R2: memory write code is not claimed
      @(negedge clk);
      ini_avld = 1; ini_cmd = 4'b0111; ini_addr = 32'h200;
      @(negedge clk);
      ini_avld = 0;
      chk(ini_claim == 0 && ini_retry == 0, "R2", "other command not claimed", 64'({ini_claim, ini_retry}), 0);
      @(negedge clk);
      chk(q_count == 2, "R2", "count unchanged", 64'(q_count), 2);

      do_write(mk(4'b0011, 32'h104), 0);
      do_write(mk(4'b1011, 32'h108), 3);
      do_write(mk(4'b0011, 32'h10c), 0);     // R6 full: refused

      // R7: no permit, no request
      repeat (3) begin
         @(negedge clk);
         chk(tgt_req == 0, "R7", "held without permit", 64'(tgt_req), 0);
      end

      // R11: stray response ignored
      tgt_rsp_vld = 1; tgt_rsp = 2'b00;
      @(negedge clk);
      tgt_rsp_vld = 0;
      chk(q_count == 4 && stat_vld == 0 && tgt_req == 0, "R11", "stray response ignored",
          64'({q_count, stat_vld, tgt_req}), 64'({3'd4, 2'b00}));

      serve(2'b01);                           // R9 retry then reissue
      serve(2'b00);
      serve(2'b10);
      serve(2'b01);
      serve(2'b11);
      serve(2'b00);

      for (int it = 0; it < 300; it++) begin
         if (mq.size() == 0 || $urandom_range(0, 1) == 0) begin
            do_write(mk($urandom_range(0, 1) ? 4'b0011 : 4'b1011, 32'h40 + 4 * $urandom_range(0, 3)),
                     $urandom_range(0, 2));
         end else begin
            serve(2'($urandom_range(0, 3)));
         end
      end
      while (mq.size() != 0) serve(2'b00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule